// File: doc/BRIEF.md
# Power-Fail Reset Sequencer

This block sits between the board-level supply monitors and the rest of a display controller. It watches a power-on sense input and an early power-good warning, and from them drives a controller reset, a park request to the display-device driver, and two active-low reset outputs: one general-purpose reset and one for the colour-wheel motor driver. Power-on sense acts at once on both outputs. Power-good is filtered: a short low is treated as a glitch, and a rise only counts after a sustained high time.

When a genuine power-good loss is seen, the sequencer asks for the display device to be parked and then holds the controller in reset until power-good is qualified again. If the park handshake never returns, a timeout forces the reset. Power-good losses and internal or lamp-strike reset requests also pulse the reset outputs after a short delay, and every such pulse is stretched to a minimum width. After power-on each output stays asserted until software releases it, and software can force either output low at any time. All timings are given in nanoseconds as parameters and converted to clock-cycle counts for a given clock frequency.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `pwr_on_sense` is low, `gen_rst_n` and `mtr_rst_n` are both low in the same cycle, with no clock edge needed, and `ctrl_rst` is high.
- R2: After `pwr_on_sense` returns high, the general output stays low until `sw_release[0]` is seen high and the motor output stays low until `sw_release[1]` is seen high (bit 0 general, bit 1 motor).
- R3: A low on `pwr_good` shorter than the glitch time causes no park request, no controller reset and no change on either reset output.
- R4: A power-good low lasting the glitch time raises `park_req`; `ctrl_rst` stays low until `park_done` arrives, then `park_req` falls, `ctrl_rst` rises and stays high while power-good remains low.
- R5: If `park_done` does not arrive, `ctrl_rst` rises once the park timeout has run out after `park_req` rose.
- R6: `ctrl_rst` is released only after `pwr_good` has stayed high for the qualification time; a shorter high leaves it asserted.
- R7: The general output goes low the delay time after an accepted power-good drop or a rising edge of `int_rst_req` (counted after the two synchronizer cycles), not before.
- R8: Each pulse of either reset output caused by an event lasts at least the minimum width, and ends a few cycles after it.
- R9: The motor output is pulsed by power-good drops and internal requests only when `cfg_mtr_on_pg` is 1; when it is 0 the motor output stays high for those events.
- R10: A rising edge of `lamp_rst_req` pulses the general output, and pulses the motor output unless `cfg_mtr_lamp_mask` is 1.
- R11: `sw_force[0]` drives the general output low and `sw_force[1]` the motor output low in the same cycle, without affecting the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| pwr_on_sense | input | 1 | Power-on sense, high when supplies are up; low resets the block asynchronously |
| pwr_good | input | 1 | Power-good warning, asynchronous |
| int_rst_req | input | 1 | Internal reset request, rising edge acts, asynchronous |
| lamp_rst_req | input | 1 | Lamp-strike reset request, rising edge acts, asynchronous |
| park_done | input | 1 | Park of the display device finished |
| cfg_mtr_on_pg | input | 1 | 1 lets power-good drops and internal requests pulse the motor output |
| cfg_mtr_lamp_mask | input | 1 | 1 stops lamp-strike requests from pulsing the motor output |
| sw_release | input | 2 | Software release after power-on; bit 0 general, bit 1 motor |
| sw_force | input | 2 | Software force low; bit 0 general, bit 1 motor |
| ctrl_rst | output | 1 | Full controller reset, active high |
| park_req | output | 1 | Request to park the display device |
| gen_rst_n | output | 1 | General reset output, active low |
| mtr_rst_n | output | 1 | Motor reset output, active low |

## Verification
A power-good change passes two synchronizer flops and then the filter count, so an accepted drop shows on `park_req` at the glitch count plus about three cycles, and the event pulse on the reset outputs follows exactly the delay count after `park_req` rises; internal and lamp requests pulse the outputs the delay count plus two cycles after the input edge. `ctrl_rst` follows `park_done` by one cycle or the park timeout count after `park_req`, and the pulse width equals the width count. The bench anchors each check on an observed edge such as the rise of `park_req`, samples on the falling clock edge, and places each check two to four cycles clear of the expected edge so that off-by-one register changes still land on the correct side. Power-on sense and software force checks are sampled within the same cycle, since both act combinationally.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_PARK = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

    localparam int CH_GEN = 0;
    localparam int CH_MTR = 1;
    localparam int N_CH   = 2;

    // Converts a time in ns into whole clock cycles, never less than one.
    function automatic int ns2cyc(input int clk_mhz, input longint t_ns);
        longint c;
        c = (longint'(clk_mhz) * t_ns) / 1000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/prs_pg_qual.sv
module prs_pg_qual #(
    parameter int GLITCH_CYC = 10,
    parameter int QUAL_CYC   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s_i,
    output logic pg_ok_o,
    output logic drop_o
);
    localparam int MAXC = (GLITCH_CYC > QUAL_CYC) ? GLITCH_CYC : QUAL_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          ok;
        logic          drop;
        logic [CW-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        logic [CW-1:0] lim;
        st_d      = st_q;
        st_d.drop = 1'b0;
        lim       = st_q.ok ? CW'(GLITCH_CYC - 1) : CW'(QUAL_CYC - 1);
        if (pg_s_i == st_q.ok) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == lim) begin
            st_d.ok   = pg_s_i;
            st_d.drop = !pg_s_i;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pg_ok_o = st_q.ok;
    assign drop_o  = st_q.drop;

    // R3: an accepted drop needs the synchronized input low
    a_r3_drop_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ok) |-> !$past(pg_s_i));

    // R6: qualification needs the synchronized input high
    a_r6_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ok) |-> $past(pg_s_i));
endmodule

// File: rtl/prs_stretch.sv
module prs_stretch #(
    parameter int WIDTH_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic active_o
);
    localparam int CW = $clog2(WIDTH_CYC + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == CW'(WIDTH_CYC - 1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    // Out of reset the pulse is already running, so a power-on also gets the full width.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R8: a fire always starts or restarts the pulse
    a_r8_fire_loads: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> st_q.active);
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
    import pwr_rst_pkg::*;
#(
    parameter int     CLK_MHZ    = 125,
    parameter longint GLITCH_NS  = 1000,
    parameter longint QUAL_NS    = 100000,
    parameter longint DELAY_NS   = 5000,
    parameter longint WIDTH_NS   = 2000000,
    parameter longint PARK_TO_NS = 500000
) (
    input  logic       clk,
    input  logic       pwr_on_sense,
    input  logic       pwr_good,
    input  logic       int_rst_req,
    input  logic       lamp_rst_req,
    input  logic       park_done,
    input  logic       cfg_mtr_on_pg,
    input  logic       cfg_mtr_lamp_mask,
    input  logic [1:0] sw_release,
    input  logic [1:0] sw_force,
    output logic       ctrl_rst,
    output logic       park_req,
    output logic       gen_rst_n,
    output logic       mtr_rst_n
);
    localparam int GLITCH_CYC  = ns2cyc(CLK_MHZ, GLITCH_NS);
    localparam int QUAL_CYC    = ns2cyc(CLK_MHZ, QUAL_NS);
    localparam int DELAY_CYC   = ns2cyc(CLK_MHZ, DELAY_NS);
    localparam int WIDTH_CYC   = ns2cyc(CLK_MHZ, WIDTH_NS);
    localparam int PARK_TO_CYC = ns2cyc(CLK_MHZ, PARK_TO_NS);
    localparam int TW          = $clog2(PARK_TO_CYC + 1);
    localparam int DW          = $clog2(DELAY_CYC + 1);

    // Reset synchronizer: asserts with power-on sense, releases on the clock.
    logic [1:0] por_q;
    logic       rst_n;

    always_ff @(posedge clk or negedge pwr_on_sense) begin
        if (!pwr_on_sense) por_q <= 2'b00;
        else               por_q <= {por_q[0], 1'b1};
    end
    assign rst_n = por_q[1];

    logic pg_s, int_s, lamp_s;

    prs_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pwr_good, int_rst_req, lamp_rst_req}),
        .dout ({pg_s, int_s, lamp_s})
    );

    logic pg_ok, pg_drop;

    prs_pg_qual #(.GLITCH_CYC(GLITCH_CYC), .QUAL_CYC(QUAL_CYC)) u_pg_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg_s_i (pg_s),
        .pg_ok_o(pg_ok),
        .drop_o (pg_drop)
    );

    typedef struct packed {
        seq_state_e      state;
        logic [TW-1:0]   tmr;
        logic            dly_busy;
        logic [DW-1:0]   dly_cnt;
        logic            dly_mtr;
        logic            int_prev;
        logic            lamp_prev;
        logic [N_CH-1:0] hold;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [N_CH-1:0] fire;
    logic [N_CH-1:0] active;
    logic            t_int, t_lamp, t_any, mtr_want, dly_done;

    always_comb begin
        t_int    = int_s & ~st_q.int_prev;
        t_lamp   = lamp_s & ~st_q.lamp_prev;
        t_any    = pg_drop | t_int | t_lamp;
        mtr_want = (cfg_mtr_on_pg & (pg_drop | t_int)) | (t_lamp & ~cfg_mtr_lamp_mask);
        dly_done = st_q.dly_busy && (st_q.dly_cnt == DW'(DELAY_CYC - 1));

        st_d           = st_q;
        st_d.int_prev  = int_s;
        st_d.lamp_prev = lamp_s;
        st_d.hold      = st_q.hold & ~sw_release;

        // Park-then-reset sequence
        unique case (st_q.state)
            SEQ_RUN: begin
                st_d.tmr = '0;
                if (pg_drop) st_d.state = SEQ_PARK;
            end
            SEQ_PARK: begin
                if (park_done || st_q.tmr == TW'(PARK_TO_CYC - 1)) begin
                    st_d.state = SEQ_HOLD;
                    st_d.tmr   = '0;
                end else begin
                    st_d.tmr = st_q.tmr + 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (pg_ok) st_d.state = SEQ_RUN;
            end
            default: st_d.state = SEQ_HOLD;
        endcase

        // Delay from a reset event to the output pulse
        if (!st_q.dly_busy || dly_done) begin
            st_d.dly_busy = t_any;
            st_d.dly_cnt  = '0;
            st_d.dly_mtr  = mtr_want;
        end else begin
            st_d.dly_cnt = st_q.dly_cnt + 1'b1;
            st_d.dly_mtr = st_q.dly_mtr | mtr_want;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= SEQ_HOLD;
            st_q.hold  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire[CH_GEN] = dly_done;
    assign fire[CH_MTR] = dly_done & st_q.dly_mtr;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        prs_stretch #(.WIDTH_CYC(WIDTH_CYC)) u_stretch (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire_i  (fire[ch]),
            .active_o(active[ch])
        );
    end

    assign gen_rst_n = pwr_on_sense & ~(st_q.hold[CH_GEN] | active[CH_GEN] | sw_force[CH_GEN]);
    assign mtr_rst_n = pwr_on_sense & ~(st_q.hold[CH_MTR] | active[CH_MTR] | sw_force[CH_MTR]);
    assign ctrl_rst  = ~pwr_on_sense | (st_q.state == SEQ_HOLD);
    assign park_req  = pwr_on_sense & (st_q.state == SEQ_PARK);

    // R4: an accepted drop while running always goes to park first
    a_r4_park_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SEQ_RUN && pg_drop) |=> (st_q.state == SEQ_PARK));

    // R5: park only ever ends in the held reset
    a_r5_park_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SEQ_PARK) |=> (st_q.state != SEQ_RUN));

    // R2: the post-power-on hold of the general output clears only on its release bit
    a_r2_gen_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold[CH_GEN]) |-> $past(sw_release[CH_GEN]));

    // R2: same for the motor output
    a_r2_mtr_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold[CH_MTR]) |-> $past(sw_release[CH_MTR]));
endmodule

// File: tb/pwr_rst_seq_tb.sv
module pwr_rst_seq_tb;
    // Bench timing at 125 MHz: glitch 10, qual 20, delay 5, width 50, park timeout 30 cycles
    localparam int DLY = 5;
    localparam int WID = 50;
    localparam int PTO = 30;

    logic       clk = 1'b0;
    logic       pwr_on_sense = 1'b0;
    logic       pwr_good = 1'b0;
    logic       int_rst_req = 1'b0;
    logic       lamp_rst_req = 1'b0;
    logic       park_done = 1'b0;
    logic       cfg_mtr_on_pg = 1'b0;
    logic       cfg_mtr_lamp_mask = 1'b0;
    logic [1:0] sw_release = 2'b00;
    logic [1:0] sw_force = 2'b00;
    logic       ctrl_rst, park_req, gen_rst_n, mtr_rst_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit saw_gen_low, saw_mtr_low, saw_park, saw_ctrl;

    always #4 clk = ~clk;

    pwr_rst_seq #(
        .CLK_MHZ(125), .GLITCH_NS(80), .QUAL_NS(160), .DELAY_NS(40),
        .WIDTH_NS(400), .PARK_TO_NS(240)
    ) u_dut (
        .clk(clk), .pwr_on_sense(pwr_on_sense), .pwr_good(pwr_good),
        .int_rst_req(int_rst_req), .lamp_rst_req(lamp_rst_req), .park_done(park_done),
        .cfg_mtr_on_pg(cfg_mtr_on_pg), .cfg_mtr_lamp_mask(cfg_mtr_lamp_mask),
        .sw_release(sw_release), .sw_force(sw_force),
        .ctrl_rst(ctrl_rst), .park_req(park_req), .gen_rst_n(gen_rst_n), .mtr_rst_n(mtr_rst_n)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        saw_gen_low = 0; saw_mtr_low = 0; saw_park = 0; saw_ctrl = 0;
    endtask

    task automatic wait_mon(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!gen_rst_n) saw_gen_low = 1;
            if (!mtr_rst_n) saw_mtr_low = 1;
            if (park_req)   saw_park = 1;
            if (ctrl_rst)   saw_ctrl = 1;
        end
    endtask

    task automatic find_park(input string req);
        bit got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (park_req) got = 1;
        end
        chk(got, req, "park_req seen", int'(got), 1);
    endtask

    task automatic t_power_on();
        wait_mon(5);
        chk(!gen_rst_n && !mtr_rst_n, "R1", "outputs low under power-on sense",
            int'({gen_rst_n, mtr_rst_n}), 0);
        chk(ctrl_rst, "R1", "ctrl_rst under power-on sense", int'(ctrl_rst), 1);
        pwr_on_sense = 1'b1;
        wait_mon(80);
        chk(!gen_rst_n && !mtr_rst_n, "R2", "outputs held before release",
            int'({gen_rst_n, mtr_rst_n}), 0);
        sw_release[0] = 1'b1;
        wait_mon(2);
        chk(gen_rst_n && !mtr_rst_n, "R2", "only general released",
            int'({gen_rst_n, mtr_rst_n}), 2);
        sw_release[1] = 1'b1;
        wait_mon(2);
        chk(mtr_rst_n, "R2", "motor released", int'(mtr_rst_n), 1);
        chk(ctrl_rst, "R6", "ctrl_rst while power-good low", int'(ctrl_rst), 1);
    endtask

    task automatic t_qualify();
        pwr_good = 1'b1;
        wait_mon(10);
        pwr_good = 1'b0;
        wait_mon(40);
        chk(ctrl_rst, "R6", "short power-good high not qualified", int'(ctrl_rst), 1);
        pwr_good = 1'b1;
        wait_mon(15);
        chk(ctrl_rst, "R6", "ctrl_rst before qualification time", int'(ctrl_rst), 1);
        wait_mon(15);
        chk(!ctrl_rst, "R6", "ctrl_rst released after qualification", int'(ctrl_rst), 0);
    endtask

    task automatic t_glitch();
        clr_mon();
        pwr_good = 1'b0;
        wait_mon(5);
        pwr_good = 1'b1;
        wait_mon(60);
        chk(!saw_park && !saw_ctrl, "R3", "glitch caused park or reset",
            int'({saw_park, saw_ctrl}), 0);
        chk(!saw_gen_low && !saw_mtr_low, "R3", "glitch touched reset outputs",
            int'({saw_gen_low, saw_mtr_low}), 0);
    endtask

    task automatic t_park_handshake();
        cfg_mtr_on_pg = 1'b1;
        pwr_good = 1'b0;
        find_park("R4");
        wait_mon(DLY - 2);
        chk(gen_rst_n, "R7", "general not low before delay", int'(gen_rst_n), 1);
        chk(!ctrl_rst, "R4", "no reset while park pending", int'(ctrl_rst), 0);
        wait_mon(4);
        chk(!gen_rst_n, "R7", "general low after delay", int'(gen_rst_n), 0);
        chk(!mtr_rst_n, "R9", "motor low with enable set", int'(mtr_rst_n), 0);
        park_done = 1'b1;
        wait_mon(1);
        park_done = 1'b0;
        chk(ctrl_rst && !park_req, "R4", "reset after park done",
            int'({ctrl_rst, park_req}), 2);
        wait_mon(42);
        chk(!gen_rst_n, "R8", "general still low inside width", int'(gen_rst_n), 0);
        wait_mon(8);
        chk(gen_rst_n && mtr_rst_n, "R8", "outputs high after width",
            int'({gen_rst_n, mtr_rst_n}), 3);
        chk(ctrl_rst, "R4", "reset held while power-good low", int'(ctrl_rst), 1);
        pwr_good = 1'b1;
        wait_mon(30);
    endtask

    task automatic t_timeout();
        cfg_mtr_on_pg = 1'b0;
        clr_mon();
        pwr_good = 1'b0;
        find_park("R5");
        wait_mon(PTO - 5);
        chk(park_req && !ctrl_rst, "R5", "still parking before timeout",
            int'({park_req, ctrl_rst}), 2);
        wait_mon(8);
        chk(ctrl_rst && !park_req, "R5", "reset after park timeout",
            int'({ctrl_rst, park_req}), 2);
        pwr_good = 1'b1;
        wait_mon(60);
        chk(saw_gen_low, "R7", "general pulsed on drop", int'(saw_gen_low), 1);
        chk(!saw_mtr_low, "R9", "motor untouched with enable clear", int'(saw_mtr_low), 0);
    endtask

    task automatic t_internal();
        cfg_mtr_on_pg = 1'b1;
        int_rst_req = 1'b1;
        wait_mon(1);
        int_rst_req = 1'b0;
        chk(gen_rst_n, "R7", "general high right after request", int'(gen_rst_n), 1);
        wait_mon(8);
        chk(!gen_rst_n && !mtr_rst_n, "R7", "internal request pulses both",
            int'({gen_rst_n, mtr_rst_n}), 0);
        wait_mon(55);
        chk(gen_rst_n && mtr_rst_n, "R8", "internal pulse ended",
            int'({gen_rst_n, mtr_rst_n}), 3);
    endtask

    task automatic t_lamp();
        cfg_mtr_lamp_mask = 1'b1;
        clr_mon();
        lamp_rst_req = 1'b1;
        wait_mon(1);
        lamp_rst_req = 1'b0;
        wait_mon(8);
        chk(!gen_rst_n, "R10", "lamp request pulses general", int'(gen_rst_n), 0);
        wait_mon(60);
        chk(!saw_mtr_low, "R10", "masked lamp leaves motor high", int'(saw_mtr_low), 0);
        cfg_mtr_lamp_mask = 1'b0;
        lamp_rst_req = 1'b1;
        wait_mon(1);
        lamp_rst_req = 1'b0;
        wait_mon(8);
        chk(!mtr_rst_n, "R10", "unmasked lamp pulses motor", int'(mtr_rst_n), 0);
        wait_mon(60);
    endtask

    task automatic t_force();
        sw_force = 2'b01;
        wait_mon(1);
        chk(!gen_rst_n && mtr_rst_n, "R11", "force general", int'({gen_rst_n, mtr_rst_n}), 1);
        sw_force = 2'b10;
        wait_mon(1);
        chk(gen_rst_n && !mtr_rst_n, "R11", "force motor", int'({gen_rst_n, mtr_rst_n}), 2);
        sw_force = 2'b00;
        wait_mon(1);
        chk(gen_rst_n && mtr_rst_n, "R11", "force removed", int'({gen_rst_n, mtr_rst_n}), 3);
    endtask

    task automatic t_power_fail_again();
        sw_release = 2'b00;
        pwr_on_sense = 1'b0;
        #1;
        chk(!gen_rst_n && !mtr_rst_n, "R1", "immediate low on power-on sense",
            int'({gen_rst_n, mtr_rst_n}), 0);
        chk(ctrl_rst, "R1", "ctrl_rst on power-on sense", int'(ctrl_rst), 1);
        wait_mon(5);
        pwr_on_sense = 1'b1;
        wait_mon(80);
        chk(!gen_rst_n && !mtr_rst_n, "R2", "held after second power-on",
            int'({gen_rst_n, mtr_rst_n}), 0);
        sw_release = 2'b01;
        wait_mon(2);
        chk(gen_rst_n && !mtr_rst_n, "R2", "second release of general",
            int'({gen_rst_n, mtr_rst_n}), 2);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_power_on();
        t_qualify();
        t_glitch();
        t_park_handshake();
        t_timeout();
        t_internal();
        t_lamp();
        t_force();
        t_power_fail_again();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule